// File: doc/BRIEF.md
# Long Right Shift with Auxiliary-Register Merge

This execution unit handles one fixed-point instruction: a long right shift whose vacated high-order positions are filled from a read-only auxiliary register. Each cycle it decodes a 32-bit instruction word and produces the register-file read indices for the two operands. It also takes the operand values, the auxiliary register value and the summary-overflow flag. One clock later it presents the target register index, the merged result and a write-enable. When the instruction asks for a record, it also presents a 4-bit condition-field update with its own enable.

The shift is built as a rotate followed by a masked merge. The low five bits of the control operand give the shift count N. The source operand is rotated left by 32 − N places, which is a right rotate by N. A mask keeps the low 32 − N bits. Bit 5 of the control operand picks the merge mode. In rotate mode, the rotated data fills the masked positions and the auxiliary register fills the top N bits. In zero-fill mode, the auxiliary register supplies the masked positions and the top N bits become zero. The auxiliary register is never written. The exception register is never touched.

The operand and auxiliary inputs are sampled on every rising clock edge. Results are registered, so a decision made in cycle k is visible at the outputs in cycle k+1. The decode class follows an internal three-way enumeration with these values:
- `K_NONE`: the word is not this instruction.
- `K_PLAIN`: a write with no record.
- `K_RECORD`: a write plus a condition update.

The registered class moves between these values with no restriction, one transition per cycle, driven only by the word presented.

Top module: `shr_mq_merge_unit`

## Requirements
- R1: An instruction word is accepted only when bits [31:26] equal 31 and bits [10:1] equal 728. Any other word leaves `dst_we` and `cond_we` low in the following cycle.
- R2: `rd_a_idx` equals instruction bits [25:21] and `rd_b_idx` equals bits [15:11], both combinationally. On an accepted word, `dst_idx` equals bits [20:16] one cycle later.
- R3: In rotate mode (`ctl_lo[5]`=0), with N=`ctl_lo[4:0]` and mask = 0xFFFFFFFF >> N, the result is (rotr(src,N) & mask) | (aux & ~mask).
- R4: In zero-fill mode (`ctl_lo[5]`=1), the result is aux & mask, so the top N bits of the result are zero.
- R5: With N=0 in rotate mode, the result equals the source operand unchanged.
- R6: Instruction bit 0 set on an accepted word raises `cond_we`, with `cond_val` = {LT,GT,EQ,SO} in bits 3..0. LT, GT and EQ compare the result with zero as a signed number. With bit 0 clear, `cond_we` stays low.
- R7: `cond_val[0]` copies `so_in` as sampled with the instruction.
- R8: Outputs appear exactly one clock after their inputs. While `rst_n` is low, `dst_we` and `cond_we` are low.
- R9: Worked cases. The first has src 0x9000300F, ctl 0x24 and aux 0xFFFFFFFF, and gives 0x0FFFFFFF. The second has src 0xB0043000, ctl 0x04, aux 0xFFFFFFFF and a record requested, and gives 0xFB004300 with condition 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_word | input | 32 | Instruction word |
| src_val | input | 32 | Source operand value |
| ctl_lo | input | 6 | Low six bits of the control operand (count and mode) |
| aux_val | input | 32 | Auxiliary register value (read only) |
| so_in | input | 1 | Summary-overflow flag |
| rd_a_idx | output | 5 | Read index of the source operand |
| rd_b_idx | output | 5 | Read index of the control operand |
| dst_idx | output | 5 | Target register index |
| dst_val | output | 32 | Merged result |
| dst_we | output | 1 | Target register write-enable |
| cond_val | output | 4 | Condition field value {LT,GT,EQ,SO} |
| cond_we | output | 1 | Condition field update enable |

## Verification
A wrong registered decode class shows at the ports one cycle after the word. It appears as a write-enable or condition enable raised for a foreign word, or missing for a valid one. A bad rotate amount or mask boundary corrupts specific bit ranges of `dst_val` in that same cycle. Each class of fault is therefore visible on the very next edge. The scoreboard compares every cycle's outputs with a model computed from the requirements, so a divergence is caught one clock after it was caused.

// File: rtl/shr_mq_pkg.sv
package shr_mq_pkg;
    parameter int XLEN     = 32;
    parameter int SHW      = $clog2(XLEN);
    parameter int IDXW     = 5;
    parameter int CONDW    = 4;
    parameter logic [5:0] PRIMARY_OP = 6'd31;
    parameter logic [9:0] EXT_OP     = 10'd728;

    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_PLAIN  = 2'd1,
        K_RECORD = 2'd2
    } op_kind_e;
endpackage

// File: rtl/shr_mq_decode.sv
module shr_mq_decode
    import shr_mq_pkg::*;
(
    input  logic [XLEN-1:0] insn,
    output op_kind_e        kind,
    output logic [IDXW-1:0] tgt_idx,
    output logic [IDXW-1:0] a_idx,
    output logic [IDXW-1:0] b_idx
);
    logic hit;

    always_comb begin
        hit     = (insn[31:26] == PRIMARY_OP) && (insn[10:1] == EXT_OP);
        a_idx   = insn[25:21];
        tgt_idx = insn[20:16];
        b_idx   = insn[15:11];
        if (!hit)
            kind = K_NONE;
        else if (insn[0])
            kind = K_RECORD;
        else
            kind = K_PLAIN;
    end
endmodule

// File: rtl/shr_mq_rotmerge.sv
module shr_mq_rotmerge
    import shr_mq_pkg::*;
(
    input  logic [XLEN-1:0] src,
    input  logic [SHW:0]    ctl,
    input  logic [XLEN-1:0] aux,
    output logic [XLEN-1:0] res
);
    localparam int DBL = 2 * XLEN;

    logic [SHW-1:0]  amt;
    logic            zfill;
    logic [DBL-1:0]  twice;
    logic [XLEN-1:0] rot;
    logic [XLEN-1:0] keep;

    always_comb begin
        amt   = ctl[SHW-1:0];
        zfill = ctl[SHW];
        twice = {src, src} >> amt;
        rot   = twice[XLEN-1:0];
    end

    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        assign keep[i] = (int'(amt) <= (XLEN - 1 - i));
        assign res[i]  = zfill ? (aux[i] & keep[i])
                               : (keep[i] ? rot[i] : aux[i]);
    end
endmodule

// File: rtl/shr_mq_condgen.sv
module shr_mq_condgen
    import shr_mq_pkg::*;
(
    input  logic [XLEN-1:0]  value,
    input  logic             so,
    output logic [CONDW-1:0] field
);
    logic is_zero;

    always_comb begin
        is_zero  = ~|value;
        field[3] = value[XLEN-1];
        field[2] = ~value[XLEN-1] & ~is_zero;
        field[1] = is_zero;
        field[0] = so;
    end
endmodule

// File: rtl/shr_mq_merge_unit.sv
module shr_mq_merge_unit
    import shr_mq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   insn_word,
    input  logic [XLEN-1:0]   src_val,
    input  logic [SHW:0]      ctl_lo,
    input  logic [XLEN-1:0]   aux_val,
    input  logic              so_in,
    output logic [IDXW-1:0]   rd_a_idx,
    output logic [IDXW-1:0]   rd_b_idx,
    output logic [IDXW-1:0]   dst_idx,
    output logic [XLEN-1:0]   dst_val,
    output logic              dst_we,
    output logic [CONDW-1:0]  cond_val,
    output logic              cond_we
);
    op_kind_e         kind_d, kind_q;
    logic [IDXW-1:0]  tgt_d, tgt_q;
    logic [XLEN-1:0]  res_d, res_q;
    logic [CONDW-1:0] cf_d, cf_q;

    shr_mq_decode u_dec (
        .insn    (insn_word),
        .kind    (kind_d),
        .tgt_idx (tgt_d),
        .a_idx   (rd_a_idx),
        .b_idx   (rd_b_idx)
    );

    shr_mq_rotmerge u_rm (
        .src (src_val),
        .ctl (ctl_lo),
        .aux (aux_val),
        .res (res_d)
    );

    shr_mq_condgen u_cg (
        .value (res_d),
        .so    (so_in),
        .field (cf_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= K_NONE;
            tgt_q  <= '0;
            res_q  <= '0;
            cf_q   <= '0;
        end else begin
            kind_q <= kind_d;
            tgt_q  <= tgt_d;
            res_q  <= res_d;
            cf_q   <= cf_d;
        end
    end

    always_comb begin
        dst_idx  = tgt_q;
        dst_val  = res_q;
        dst_we   = 1'b0;
        cond_we  = 1'b0;
        cond_val = '0;
        unique case (kind_q)
            K_NONE: begin
                dst_we = 1'b0;
            end
            K_PLAIN: begin
                dst_we = 1'b1;
            end
            K_RECORD: begin
                dst_we   = 1'b1;
                cond_we  = 1'b1;
                cond_val = cf_q;
            end
            default: begin
                dst_we = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/shr_mq_merge_unit_chk.sv
module shr_mq_merge_unit_chk
    import shr_mq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [XLEN-1:0]  insn_word,
    input logic [XLEN-1:0]  src_val,
    input logic [SHW:0]     ctl_lo,
    input logic             so_in,
    input logic [IDXW-1:0]  dst_idx,
    input logic [XLEN-1:0]  dst_val,
    input logic             dst_we,
    input logic [CONDW-1:0] cond_val,
    input logic             cond_we
);
    assert_accept_only_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> ($past(insn_word[31:26]) == PRIMARY_OP && $past(insn_word[10:1]) == EXT_OP));

    assert_target_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> dst_idx == $past(insn_word[20:16]));

    assert_zero_fill_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && $past(ctl_lo[SHW]) && $past(ctl_lo[SHW-1:0]) != '0) |-> !dst_val[XLEN-1]);

    assert_identity_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && $past(ctl_lo) == '0) |-> dst_val == $past(src_val));

    assert_record_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cond_we |-> (dst_we && $past(insn_word[0])));

    assert_one_compare_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cond_we |-> $countones(cond_val[3:1]) == 1);

    assert_so_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cond_we |-> cond_val[0] == $past(so_in));
endmodule

bind shr_mq_merge_unit shr_mq_merge_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_word (insn_word),
    .src_val   (src_val),
    .ctl_lo    (ctl_lo),
    .so_in     (so_in),
    .dst_idx   (dst_idx),
    .dst_val   (dst_val),
    .dst_we    (dst_we),
    .cond_val  (cond_val),
    .cond_we   (cond_we)
);

// File: tb/shr_mq_merge_unit_bench.sv
`timescale 1ns/1ps
module shr_mq_merge_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn_word = '0;
    logic [31:0] src_val = '0;
    logic [5:0]  ctl_lo = '0;
    logic [31:0] aux_val = '0;
    logic        so_in = 1'b0;
    logic [4:0]  rd_a_idx, rd_b_idx, dst_idx;
    logic [31:0] dst_val;
    logic        dst_we, cond_we;
    logic [3:0]  cond_val;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          stamp;
        string       tag;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] val;
        logic        cwe;
        logic [3:0]  cval;
    } exp_t;

    exp_t sb[$];

    shr_mq_merge_unit u_shr_mq_merge_unit (
        .clk (clk), .rst_n (rst_n), .insn_word (insn_word), .src_val (src_val),
        .ctl_lo (ctl_lo), .aux_val (aux_val), .so_in (so_in),
        .rd_a_idx (rd_a_idx), .rd_b_idx (rd_b_idx), .dst_idx (dst_idx),
        .dst_val (dst_val), .dst_we (dst_we), .cond_val (cond_val), .cond_we (cond_we)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [9:0] xo,
                                       input logic [4:0] a, input logic [4:0] t,
                                       input logic [4:0] b, input logic rc);
        return {op, a, t, b, xo, rc};
    endfunction

    function automatic logic [31:0] model(input logic [31:0] s, input logic [5:0] c,
                                          input logic [31:0] x);
        logic [63:0] d;
        logic [31:0] m;
        d = {s, s} >> c[4:0];
        m = 32'hFFFF_FFFF >> c[4:0];
        if (c[5]) return x & m;
        return (d[31:0] & m) | (x & ~m);
    endfunction

    task automatic issue(input string tag, input logic [31:0] iw, input logic [31:0] s,
                         input logic [5:0] c, input logic [31:0] x, input logic so);
        exp_t e;
        logic [31:0] r;
        logic hit;
        @(negedge clk);
        insn_word = iw; src_val = s; ctl_lo = c; aux_val = x; so_in = so;
        hit = (iw[31:26] == 6'd31) && (iw[10:1] == 10'd728);
        r = model(s, c, x);
        e.stamp = cyc;
        e.tag   = tag;
        e.we    = hit;
        e.idx   = iw[20:16];
        e.val   = r;
        e.cwe   = hit && iw[0];
        e.cval  = {r[31], !r[31] && (r != 0), r == 0, so};
        sb.push_back(e);
        #1;
        check({tag, " R2 read indices"}, {22'd0, rd_a_idx, rd_b_idx}, {22'd0, iw[25:21], iw[15:11]});
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].stamp < cyc) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " R8 dst_we"}, {31'd0, dst_we}, {31'd0, e.we});
            check({e.tag, " R6 cond_we"}, {31'd0, cond_we}, {31'd0, e.cwe});
            if (e.we) begin
                check({e.tag, " R2 dst_idx"}, {27'd0, dst_idx}, {27'd0, e.idx});
                check({e.tag, " R3 dst_val"}, dst_val, e.val);
            end
            if (e.cwe)
                check({e.tag, " R7 cond_val"}, {28'd0, cond_val}, {28'd0, e.cval});
        end
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] ok0, ok1, bad;
        ok0 = mk(6'd31, 10'd728, 5'd4, 5'd6, 5'd8, 1'b0);
        ok1 = mk(6'd31, 10'd728, 5'd4, 5'd6, 5'd8, 1'b1);
        repeat (3) @(negedge clk);
        check("R8 reset dst_we", {31'd0, dst_we}, 32'd0);
        check("R8 reset cond_we", {31'd0, cond_we}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        issue("R9 vector one", ok0, 32'h9000300F, 6'h24, 32'hFFFFFFFF, 1'b0);
        issue("R9 vector two", ok1, 32'hB0043000, 6'h04, 32'hFFFFFFFF, 1'b0);
        issue("R1 bad primary", mk(6'd30, 10'd728, 5'd1, 5'd2, 5'd3, 1'b1), 32'h1234, 6'h0, 32'h0, 1'b0);
        issue("R1 bad extended", mk(6'd31, 10'd729, 5'd1, 5'd2, 5'd3, 1'b1), 32'h1234, 6'h0, 32'h0, 1'b0);
        issue("R5 zero count", mk(6'd31, 10'd728, 5'd9, 5'd17, 5'd2, 1'b1), 32'hCAFE0001, 6'h00, 32'h55AA55AA, 1'b1);
        issue("R4 zero fill n0", ok0, 32'hDEADBEEF, 6'h20, 32'h87654321, 1'b0);
        issue("R4 zero fill n31", ok1, 32'hDEADBEEF, 6'h3F, 32'hFFFFFFFF, 1'b0);
        issue("R3 count 31", ok1, 32'h80000001, 6'h1F, 32'h00000000, 1'b1);
        issue("R6 zero result", ok1, 32'h0, 6'h08, 32'h00FFFFFF, 1'b0);
        issue("R6 positive", mk(6'd31, 10'd728, 5'd31, 5'd0, 5'd31, 1'b1), 32'h00000010, 6'h04, 32'h0, 1'b1);
        issue("R6 no record", ok0, 32'hF0F0F0F0, 6'h10, 32'h0F0F0F0F, 1'b1);
        for (int k = 0; k < 40; k++) begin
            issue("R3 sweep", mk(6'd31, 10'd728, 5'(k), 5'(k + 3), 5'(k + 7), k[0]),
                  32'hA5C3_0000 ^ (32'h01010101 * k), 6'(k * 7), 32'h3C3C_F00F + k, k[1]);
        end
        issue("R1 trailing idle", 32'h0, 32'h0, 6'h0, 32'h0, 1'b0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule